// File: doc/BRIEF.md
# Self-Synchronizing Serial Scrambler Pair

This block holds both halves of a bit-serial multiplicative scrambler link. The transmit half divides the data stream by a generator polynomial over GF(2). Each outgoing bit is the input bit XORed with selected earlier outgoing bits, so that half feeds back its own output history. The receive half multiplies by the same polynomial. Its shift register is loaded only from received line bits and has no feedback path. As a result it falls into step with the transmitter by itself, without any seed exchange or frame marker, once a register length of line bits has passed through it.

The receive half also watches the recovered stream. A run of identical recovered bits longer than a set limit suggests a bit slip, so the block raises a one-bit slip pulse with that bit. For a register-length window after a slip, and for the first register length of bits after reset, recovered bits are marked as suspect. The monitor is a small state machine with three states. FILL is entered at reset and covers the register filling up. LOCK is the trusted state. FLUSH covers the window after a slip. There are three transitions. FILL goes to LOCK when its window count runs out, FLUSH goes to LOCK when its window count runs out, and any state goes to FLUSH on a slip. The tap set, the register length, the run limit and the window length are parameters. The defaults are delays 18 and 23 on a 23-stage register, a run limit of 23 and a 23-bit window.

Top module: `ssync_scrambler_pair`

## Requirements
- R1: With the default taps, the scrambler output is y(n) = x(n) XOR y(n-18) XOR y(n-23), using earlier outputs taken as 0 after reset. The output and its valid flag are registered and appear in the cycle after the accepted input.
- R2: The descrambler output is r(n) XOR r(n-18) XOR r(n-23) over received bits r, with one cycle of registered latency. From any starting history, every output from the 24th received bit onward equals the data that produced the line stream. This also holds after one line bit has been dropped, once 23 further bits have been received.
- R3: Flipping a single line bit corrupts exactly three recovered bits, at offsets 0, 18 and 23 after that bit.
- R4: When an input valid is low, that side does not advance its register. In the next cycle its output valid is low, and on the receive side the slip and suspect outputs are low as well.
- R5: During reset and right after it, every output is 0 and both shift registers hold all zeros.
- R6: The first 23 recovered bits after reset are marked suspect (the FILL state).
- R7: The slip output pulses with the recovered bit that makes a run of identical bits exceed the run limit of 23, which means the 24th equal bit. The run count then clears, so another slip needs a fresh run of 24.
- R8: The 23 recovered bits that follow a slip are marked suspect (the FLUSH state). After that the monitor returns to LOCK and marks nothing.
- R9: The bit that raises a slip is itself marked suspect only if the monitor was still in FILL or FLUSH when that bit arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bit_in | input | 1 | Data bit to scramble |
| tx_vld_in | input | 1 | tx_bit_in is valid this cycle |
| tx_bit_out | output | 1 | Scrambled line bit |
| tx_vld_out | output | 1 | tx_bit_out is valid |
| rx_bit_in | input | 1 | Received line bit |
| rx_vld_in | input | 1 | rx_bit_in is valid this cycle |
| rx_bit_out | output | 1 | Recovered data bit |
| rx_vld_out | output | 1 | rx_bit_out is valid |
| rx_slip | output | 1 | Run-length slip pulse, aligned with rx_bit_out |
| rx_suspect | output | 1 | Recovered bit lies in a fill or flush window |

## Verification
The bench seeds the line model with a random history, to show that the receiver locks by itself. A receiver with the wrong tap delay, or with feedback from its own output, would never match the data after bit 23. A single flipped line bit must give exactly three errors at offsets 0, 18 and 23. A design that fed its output back would spread the error without end, and wrong taps would move the error positions. An all-zero line stream forces slips at recovered bits 23 and 47. A run counter that was off by one, or that did not clear after a slip, would move or duplicate these pulses, and a wrong window length would shift the edges of the suspect flag. Random valid gaps on both sides show whether a register advances on an idle cycle, because every later output would then differ from the bench model.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        MON_FILL  = 2'd0,
        MON_LOCK  = 2'd1,
        MON_FLUSH = 2'd2
    } mon_state_e;

endpackage

// File: rtl/scr_tx_div.sv
module scr_tx_div #(
    parameter int               DEG      = 23,
    parameter logic [DEG-1:0]   TAP_MASK = 23'h420000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic vld_in,
    output logic bit_out,
    output logic vld_out
);

    logic [DEG-1:0] hist_q;
    logic           fb_bit;
    logic           line_bit;

    always_comb begin
        fb_bit   = ^(hist_q & TAP_MASK);
        line_bit = bit_in ^ fb_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= '0;
            bit_out <= 1'b0;
            vld_out <= 1'b0;
        end else begin
            vld_out <= vld_in;
            if (vld_in) begin
                hist_q  <= {hist_q[DEG-2:0], line_bit};
                bit_out <= line_bit;
            end else begin
                bit_out <= 1'b0;
            end
        end
    end

    AST_TX_FEEDS_OWN_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        vld_in |=> (hist_q[0] == bit_out)) else $error("tx history not fed by output"); // R1
    AST_TX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_in |=> $stable(hist_q)) else $error("tx advanced while idle"); // R4

endmodule

// File: rtl/scr_rx_mul.sv
module scr_rx_mul #(
    parameter int               DEG      = 23,
    parameter logic [DEG-1:0]   TAP_MASK = 23'h420000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic vld_in,
    output logic dec_bit,
    output logic bit_out,
    output logic vld_out
);

    logic [DEG-1:0] hist_q;

    always_comb begin
        dec_bit = bit_in ^ (^(hist_q & TAP_MASK));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= '0;
            bit_out <= 1'b0;
            vld_out <= 1'b0;
        end else begin
            vld_out <= vld_in;
            if (vld_in) begin
                hist_q  <= {hist_q[DEG-2:0], bit_in};
                bit_out <= dec_bit;
            end else begin
                bit_out <= 1'b0;
            end
        end
    end

    AST_RX_LOADS_LINE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        vld_in |=> (hist_q[0] == $past(bit_in))) else $error("rx history not fed by line"); // R2
    AST_RX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_in |=> $stable(hist_q)) else $error("rx advanced while idle"); // R4

endmodule

// File: rtl/scr_rx_monitor.sv
module scr_rx_monitor
    import scr_pkg::*;
#(
    parameter int RUN_MAX = 23,
    parameter int WIN     = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_val,
    input  logic bit_vld,
    output logic slip_o,
    output logic suspect_o
);

    localparam int RUN_W = $clog2(RUN_MAX + 2);
    localparam int WIN_W = $clog2(WIN + 1);

    mon_state_e       state_q, state_d;
    logic [RUN_W-1:0] run_q, run_inc, run_d;
    logic [WIN_W-1:0] win_q, win_d;
    logic             last_q;
    logic             slip_hit;
    logic             in_window;

    always_comb begin
        run_inc   = ((run_q != '0) && (bit_val == last_q)) ? run_q + RUN_W'(1) : RUN_W'(1);
        slip_hit  = bit_vld && (run_inc > RUN_W'(RUN_MAX));
        in_window = (state_q != MON_LOCK);
        run_d     = run_q;
        state_d   = state_q;
        win_d     = win_q;
        if (bit_vld) begin
            run_d = slip_hit ? '0 : run_inc;
            if (slip_hit) begin
                state_d = MON_FLUSH;
                win_d   = WIN_W'(WIN);
            end else begin
                unique case (state_q)
                    MON_FILL, MON_FLUSH: begin
                        win_d = win_q - WIN_W'(1);
                        if (win_q == WIN_W'(1)) state_d = MON_LOCK;
                    end
                    MON_LOCK: begin
                        state_d = MON_LOCK;
                    end
                    default: begin
                        state_d = MON_FILL;
                        win_d   = WIN_W'(WIN);
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MON_FILL;
            win_q   <= WIN_W'(WIN);
            run_q   <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
            run_q   <= run_d;
            if (bit_vld) last_q <= bit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slip_o    <= 1'b0;
            suspect_o <= 1'b0;
        end else begin
            slip_o    <= slip_hit;
            suspect_o <= bit_vld && in_window;
        end
    end

    AST_SLIP_ENTERS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        slip_o |-> (state_q == MON_FLUSH && win_q == WIN_W'(WIN))) else $error("slip without flush"); // R8
    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_o || suspect_o) |-> $past(bit_vld)) else $error("flag on idle cycle"); // R4
    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(RUN_MAX)) else $error("run count overflow"); // R7
    AST_SLIP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        slip_o |-> (run_q == '0)) else $error("run not cleared after slip"); // R7

endmodule

// File: rtl/ssync_scrambler_pair.sv
module ssync_scrambler_pair #(
    parameter int             DEG      = 23,
    parameter logic [DEG-1:0] TAP_MASK = 23'h420000,
    parameter int             RUN_MAX  = 23,
    parameter int             WIN      = DEG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_bit_in,
    input  logic tx_vld_in,
    output logic tx_bit_out,
    output logic tx_vld_out,
    input  logic rx_bit_in,
    input  logic rx_vld_in,
    output logic rx_bit_out,
    output logic rx_vld_out,
    output logic rx_slip,
    output logic rx_suspect
);

    logic rx_dec_bit;

    scr_tx_div #(.DEG(DEG), .TAP_MASK(TAP_MASK)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (tx_bit_in),
        .vld_in  (tx_vld_in),
        .bit_out (tx_bit_out),
        .vld_out (tx_vld_out)
    );

    scr_rx_mul #(.DEG(DEG), .TAP_MASK(TAP_MASK)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (rx_bit_in),
        .vld_in  (rx_vld_in),
        .dec_bit (rx_dec_bit),
        .bit_out (rx_bit_out),
        .vld_out (rx_vld_out)
    );

    scr_rx_monitor #(.RUN_MAX(RUN_MAX), .WIN(WIN)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_val   (rx_dec_bit),
        .bit_vld   (rx_vld_in),
        .slip_o    (rx_slip),
        .suspect_o (rx_suspect)
    );

    AST_SLIP_ON_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_slip |-> rx_vld_out) else $error("slip without valid output"); // R7

endmodule

// File: tb/sim_ssync_scrambler_pair.sv
module sim_ssync_scrambler_pair;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_bit_in = 1'b0, tx_vld_in = 1'b0;
    logic rx_bit_in = 1'b0, rx_vld_in = 1'b0;
    logic tx_bit_out, tx_vld_out, rx_bit_out, rx_vld_out, rx_slip, rx_suspect;

    always #2.5 clk = ~clk;

    ssync_scrambler_pair u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_bit_in(tx_bit_in), .tx_vld_in(tx_vld_in),
        .tx_bit_out(tx_bit_out), .tx_vld_out(tx_vld_out),
        .rx_bit_in(rx_bit_in), .rx_vld_in(rx_vld_in),
        .rx_bit_out(rx_bit_out), .rx_vld_out(rx_vld_out),
        .rx_slip(rx_slip), .rx_suspect(rx_suspect)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [22:0] tx_h, rx_h, line_h;
    int  m_run, m_win, rx_idx;
    bit  m_last;
    bit  exp_slip, exp_susp;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit taps(input logic [22:0] h);
        return h[17] ^ h[22];
    endfunction

    task automatic model_reset();
        tx_h = '0; rx_h = '0; m_run = 0; m_last = 0; m_win = 23; rx_idx = 0;
    endtask

    // one clock: drive, clock, then compare registered outputs against models
    task automatic cyc(input bit tv, input bit tb, input bit rv, input bit rb);
        bit e, d, nr_ok;
        int nr;
        @(negedge clk);
        tx_vld_in = tv; tx_bit_in = tb; rx_vld_in = rv; rx_bit_in = rb;
        @(posedge clk); #1;
        if (tv) begin
            e = tb ^ taps(tx_h);
            tx_h = {tx_h[21:0], e};
            check(tx_vld_out == 1'b1 && tx_bit_out == e, "R1 tx bit", tx_bit_out, e);
        end else begin
            check(tx_vld_out == 1'b0, "R4 tx idle", tx_vld_out, 0);
        end
        if (rv) begin
            d = rb ^ taps(rx_h);
            rx_h = {rx_h[21:0], rb};
            exp_susp = (m_win > 0);
            nr_ok = (m_run > 0) && (d == m_last);
            nr = nr_ok ? m_run + 1 : 1;
            exp_slip = (nr > 23);
            m_run = exp_slip ? 0 : nr;
            m_last = d;
            if (exp_slip) m_win = 23; else if (m_win > 0) m_win--;
            check(rx_vld_out == 1'b1 && rx_bit_out == d, "R2 rx bit", rx_bit_out, d);
            check(rx_slip == exp_slip, "R7 slip", rx_slip, exp_slip);
            check(rx_suspect == exp_susp, "R6/R8/R9 suspect", rx_suspect, exp_susp);
            rx_idx++;
        end else begin
            check(rx_vld_out == 0 && rx_slip == 0 && rx_suspect == 0, "R4 rx idle",
                  {rx_vld_out, rx_slip, rx_suspect}, 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; tx_vld_in = 0; rx_vld_in = 0; tx_bit_in = 0; rx_bit_in = 0;
        repeat (3) @(posedge clk);
        #1;
        check({tx_bit_out, tx_vld_out, rx_bit_out, rx_vld_out, rx_slip, rx_suspect} == 6'b0,
              "R5 reset outputs", {tx_bit_out, tx_vld_out, rx_bit_out, rx_vld_out, rx_slip, rx_suspect}, 0);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    // loopback: bench-scrambled line stream with optional error/drop; returns mismatch counts
    task automatic loopback(input int len, input int flip_at, input int drop_at,
                            output int bad_early, output int bad_win, output int bad_late, input int ref_at);
        bit m, s;
        bad_early = 0; bad_win = 0; bad_late = 0;
        line_h = 23'($urandom) | 23'h1;
        for (int i = 0; i < len; i++) begin
            m = 1'($urandom);
            s = m ^ taps(line_h);
            line_h = {line_h[21:0], s};
            if (i == drop_at) continue;
            if (i == flip_at) s = ~s;
            cyc(1'b0, 1'b0, 1'b1, s);
            if (rx_bit_out != m) begin
                if (i < ref_at) bad_early++;
                else if (i <= ref_at + 23) bad_win++;
                else bad_late++;
            end
        end
    endtask

    initial begin
        #(5ns * 200000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int be, bw, bl, slips;
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R6, R7, R8, R9: all-zero line -> slips at recovered bits 23 and 47
        slips = 0;
        for (int i = 0; i < 60; i++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b0);
            if (i == 23) check(rx_slip == 1 && rx_suspect == 0, "R7 first slip at bit 23 (R9 not suspect)",
                               {rx_slip, rx_suspect}, 2);
            if (i == 22) check(rx_suspect == 1, "R6 last fill bit suspect", rx_suspect, 1);
            if (i == 46) check(rx_suspect == 1, "R8 last flush bit suspect", rx_suspect, 1);
            if (i == 47) check(rx_slip == 1 && rx_suspect == 0, "R7 second slip after fresh run",
                               {rx_slip, rx_suspect}, 2);
            slips += rx_slip;
        end
        check(slips == 2, "R7 slip count on zero run", slips, 2);

        // R2: self-lock from random history
        do_reset();
        loopback(300, -1, -1, be, bw, bl, 23);
        check(bw + bl == 0, "R2 locked after 23 bits", bw + bl, 0);

        // R3: single line error -> exactly three errors
        loopback(300, 150, -1, be, bw, bl, 150);
        check(bw == 3 && bl == 0, "R3 error multiplication", bw, 3);

        // R2: dropped line bit -> realigned after 23 more bits
        loopback(300, -1, 120, be, bw, bl, 120);
        check(bl == 0, "R2 realign after drop", bl, 0);

        // R1, R4: random data with random valid gaps on both sides
        do_reset();
        for (int i = 0; i < 4000; i++)
            cyc(1'($urandom_range(0, 2) != 0), 1'($urandom), 1'($urandom_range(0, 2) != 0), 1'($urandom));

        // R5: reset mid-run clears histories (tx restarts from zero history)
        do_reset();
        for (int i = 0; i < 100; i++) cyc(1'b1, 1'($urandom), 1'b1, 1'($urandom));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule